// File: doc/BRIEF.md
# Global Address Extension Annex

This block sits next to a processor whose physical address is 34 bits wide and turns each of its accesses into a global address. A global address names a processing element (PE) and a byte offset inside that PE's memory. The top 5 bits of the processor address select one of 32 annex entries. Each entry supplies an 11-bit destination PE number and a 2-bit cache mode. The lower 29 bits pass through unchanged as the offset. Together the PE number and the offset give a 40-bit global address.

Each translated access is compared with the PE number of this node. A match sends the access straight to local memory. Any other PE number sends it to the remote request path. The annex entries are loaded through a simple register write port. A write becomes visible to the access issued on the next cycle, and the block never stalls.

Top module: `ga_annex`

## Requirements
- R1: While `rst_n` is low, both output valids are low. After reset, every entry holds PE = `node_pe` and cache mode 2'b00 (uncached). Any access made before the first write is therefore steered local and uncached.
- R2: Entry index is `acc_addr[33:29]`. `out_offset` equals `acc_addr[28:0]` of the access.
- R3: `out_pe` and `out_mode` equal the PE number and cache mode held in the selected entry.
- R4: When the selected PE equals `node_pe`, `out_local` is high and `out_remote` is low.
- R5: When the selected PE differs from `node_pe`, `out_remote` is high and `out_local` is low.
- R6: Cache mode 2'b01 means cached and drives `out_cached` high. Modes 2'b00, 2'b10 and 2'b11 drive `out_cached` low, and the stored code is still reported on `out_mode`.
- R7: A write with `cfg_we` high in cycle N is seen by an access issued in cycle N+1 or later. An access issued in cycle N itself sees the old entry contents.
- R8: Results appear exactly one cycle after `acc_valid`. A cycle with `acc_valid` low produces no valid output in the following cycle.
- R9: `out_local` and `out_remote` are never high together.
- R10: A write changes only the entry named by `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_pe | input | 11 | PE number of this node (held stable) |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 5 | Entry to write |
| cfg_pe | input | 11 | PE number to store |
| cfg_mode | input | 2 | Cache mode to store (00 uncached, 01 cached, 10/11 uncached) |
| acc_valid | input | 1 | Processor access present |
| acc_addr | input | 34 | Processor physical byte address |
| out_local | output | 1 | Translated access targets local memory |
| out_remote | output | 1 | Translated access targets the remote path |
| out_pe | output | 11 | Destination PE number |
| out_offset | output | 29 | Offset within the destination PE |
| out_mode | output | 2 | Stored cache-mode code |
| out_cached | output | 1 | Access may be cached |

## Verification
A corrupted entry shows up on the very next access that selects it. It appears as a wrong `out_pe` or `out_mode`, and often as a local/remote flip, one cycle after that access. Between writes the bench keeps a model of all 32 entries and sweeps or randomly revisits every index. A write landing on the wrong entry, or a reset value that is wrong, is therefore exposed within a few accesses. A write that takes effect a cycle early or late is caught by the directed case where an access to the same index is issued in the write cycle and again in the next cycle.

// File: rtl/ga_pkg.sv
// Shared definitions for the global address extension annex.
// Assumes the cache-mode field is always two bits wide.
package ga_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CM_UNCACHED = 2'b00,
        CM_CACHED   = 2'b01,
        CM_RSV_A    = 2'b10,
        CM_RSV_B    = 2'b11
    } cmode_e;
endpackage

// File: rtl/ga_annex_regs.sv
// Annex entry storage: one PE number and one cache mode per entry.
// Assumes node_pe is stable while reset is applied; reset loads it.
module ga_annex_regs
    import ga_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int PE_W  = 11,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PE_W-1:0]   node_pe,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PE_W-1:0]   wr_pe,
    input  logic [MODE_W-1:0] wr_mode,
    output logic [PE_W-1:0]   ent_pe   [ENTRIES],
    output logic [MODE_W-1:0] ent_mode [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Hold entry g; reload to node/uncached on reset, update on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_pe[g]   <= node_pe;
                ent_mode[g] <= CM_UNCACHED;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_pe[g]   <= wr_pe;
                ent_mode[g] <= wr_mode;
            end
        end
    end
endmodule

// File: rtl/ga_annex_lookup.sv
// Combinational translation: splits the address, selects an entry,
// compares its PE with the node PE and decodes the cache mode.
module ga_annex_lookup
    import ga_pkg::*;
#(
    parameter int PADDR_W = 34,
    parameter int IDX_W   = 5,
    parameter int PE_W    = 11,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int OFF_W   = PADDR_W - IDX_W
) (
    input  logic [PADDR_W-1:0] addr,
    input  logic [PE_W-1:0]    node_pe,
    input  logic [PE_W-1:0]    ent_pe   [ENTRIES],
    input  logic [MODE_W-1:0]  ent_mode [ENTRIES],
    output logic [PE_W-1:0]    sel_pe,
    output logic [MODE_W-1:0]  sel_mode,
    output logic [OFF_W-1:0]   offset,
    output logic               is_local,
    output logic               cacheable
);
    logic [IDX_W-1:0] idx;

    // Split the processor address into entry index and offset.
    always_comb begin
        idx    = addr[PADDR_W-1:OFF_W];
        offset = addr[OFF_W-1:0];
    end

    // Select the entry and derive the steering and caching decisions.
    always_comb begin
        sel_pe    = ent_pe[idx];
        sel_mode  = ent_mode[idx];
        is_local  = (sel_pe == node_pe);
        cacheable = (sel_mode == CM_CACHED);
    end
endmodule

// File: rtl/ga_annex_steer.sv
// Output stage: registers one translated access and raises exactly one
// of the local/remote valids. Assumes a single access per cycle.
module ga_annex_steer
    import ga_pkg::*;
#(
    parameter int PE_W  = 11,
    parameter int OFF_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_local,
    input  logic [PE_W-1:0]   in_pe,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [MODE_W-1:0] in_mode,
    input  logic              in_cached,
    output logic              out_local,
    output logic              out_remote,
    output logic [PE_W-1:0]   out_pe,
    output logic [OFF_W-1:0]  out_offset,
    output logic [MODE_W-1:0] out_mode,
    output logic              out_cached
);
    // Steering valids: cleared on reset, one-hot on a valid access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_local  <= 1'b0;
            out_remote <= 1'b0;
        end else begin
            out_local  <= in_valid && in_local;
            out_remote <= in_valid && !in_local;
        end
    end

    // Payload: captured with each valid access, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pe     <= '0;
            out_offset <= '0;
            out_mode   <= CM_UNCACHED;
            out_cached <= 1'b0;
        end else if (in_valid) begin
            out_pe     <= in_pe;
            out_offset <= in_offset;
            out_mode   <= in_mode;
            out_cached <= in_cached;
        end
    end
endmodule

// File: rtl/ga_annex.sv
// Global address extension annex top. Translates a processor physical
// address into {PE, offset} through a written entry table and steers it
// local or remote. Writes are seen by accesses on the following cycle.
module ga_annex
    import ga_pkg::*;
#(
    parameter int PADDR_W = 34,
    parameter int IDX_W   = 5,
    parameter int PE_W    = 11,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int OFF_W   = PADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PE_W-1:0]    node_pe,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PE_W-1:0]    cfg_pe,
    input  logic [1:0]         cfg_mode,
    input  logic               acc_valid,
    input  logic [PADDR_W-1:0] acc_addr,
    output logic               out_local,
    output logic               out_remote,
    output logic [PE_W-1:0]    out_pe,
    output logic [OFF_W-1:0]   out_offset,
    output logic [1:0]         out_mode,
    output logic               out_cached
);
    logic [PE_W-1:0]   ent_pe   [ENTRIES];
    logic [MODE_W-1:0] ent_mode [ENTRIES];
    logic [PE_W-1:0]   sel_pe;
    logic [MODE_W-1:0] sel_mode;
    logic [OFF_W-1:0]  offset;
    logic              is_local;
    logic              cacheable;

    ga_annex_regs #(.IDX_W(IDX_W), .PE_W(PE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .node_pe(node_pe),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_pe(cfg_pe), .wr_mode(cfg_mode),
        .ent_pe(ent_pe), .ent_mode(ent_mode)
    );

    ga_annex_lookup #(.PADDR_W(PADDR_W), .IDX_W(IDX_W), .PE_W(PE_W)) u_lookup (
        .addr(acc_addr), .node_pe(node_pe),
        .ent_pe(ent_pe), .ent_mode(ent_mode),
        .sel_pe(sel_pe), .sel_mode(sel_mode), .offset(offset),
        .is_local(is_local), .cacheable(cacheable)
    );

    ga_annex_steer #(.PE_W(PE_W), .OFF_W(OFF_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .in_valid(acc_valid), .in_local(is_local),
        .in_pe(sel_pe), .in_offset(offset), .in_mode(sel_mode), .in_cached(cacheable),
        .out_local(out_local), .out_remote(out_remote), .out_pe(out_pe),
        .out_offset(out_offset), .out_mode(out_mode), .out_cached(out_cached)
    );
endmodule

// File: rtl/ga_annex_chk.sv
// Port-level temporal checks for ga_annex, attached with bind.
module ga_annex_chk #(
    parameter int PADDR_W = 34,
    parameter int IDX_W   = 5,
    parameter int PE_W    = 11,
    localparam int OFF_W  = PADDR_W - IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PE_W-1:0]    node_pe,
    input logic               acc_valid,
    input logic [PADDR_W-1:0] acc_addr,
    input logic               out_local,
    input logic               out_remote,
    input logic [PE_W-1:0]    out_pe,
    input logic [OFF_W-1:0]   out_offset,
    input logic [1:0]         out_mode,
    input logic               out_cached
);
    // R9: never both destinations
    a_r9_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_local && out_remote));
    // R8: a valid result needs an access one cycle earlier
    a_r8_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(out_local || out_remote));
    // R8: every access produces a result one cycle later
    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (out_local || out_remote));
    // R2: offset passes through unchanged
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (out_offset == $past(acc_addr[OFF_W-1:0])));
    // R4: local steering only for the node's own PE
    a_r4_local_pe: assert property (@(posedge clk) disable iff (!rst_n)
        out_local |-> (out_pe == node_pe));
    // R5: remote steering only for a foreign PE
    a_r5_remote_pe: assert property (@(posedge clk) disable iff (!rst_n)
        out_remote |-> (out_pe != node_pe));
    // R6: cached flag only for the cached code
    a_r6_cached_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_local || out_remote) |-> (out_cached == (out_mode == 2'b01)));
endmodule

bind ga_annex ga_annex_chk #(.PADDR_W(PADDR_W), .IDX_W(IDX_W), .PE_W(PE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .node_pe(node_pe), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .out_local(out_local), .out_remote(out_remote),
    .out_pe(out_pe), .out_offset(out_offset), .out_mode(out_mode),
    .out_cached(out_cached)
);

// File: tb/sim_ga_annex.sv
`timescale 1ns/1ps
module sim_ga_annex;
    localparam int PADDR_W = 34;
    localparam int IDX_W   = 5;
    localparam int PE_W    = 11;
    localparam int OFF_W   = PADDR_W - IDX_W;
    localparam int N       = 1 << IDX_W;
    localparam logic [PE_W-1:0] NODE = 11'h2A5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [PE_W-1:0]    node_pe = NODE;
    logic               cfg_we = 1'b0;
    logic [IDX_W-1:0]   cfg_idx = '0;
    logic [PE_W-1:0]    cfg_pe = '0;
    logic [1:0]         cfg_mode = '0;
    logic               acc_valid = 1'b0;
    logic [PADDR_W-1:0] acc_addr = '0;
    logic               out_local, out_remote, out_cached;
    logic [PE_W-1:0]    out_pe;
    logic [OFF_W-1:0]   out_offset;
    logic [1:0]         out_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [PE_W-1:0] m_pe   [N];
    logic [1:0]      m_mode [N];

    ga_annex u0 (
        .clk(clk), .rst_n(rst_n), .node_pe(node_pe), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_pe(cfg_pe), .cfg_mode(cfg_mode),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .out_local(out_local),
        .out_remote(out_remote), .out_pe(out_pe), .out_offset(out_offset),
        .out_mode(out_mode), .out_cached(out_cached)
    );

    always #4 clk = ~clk;

    // Expected {local, remote, pe, offset, mode, cached} from the model.
    function automatic logic [44:0] expect_vec(input logic av, input logic [PADDR_W-1:0] a);
        logic [IDX_W-1:0] i;
        logic [PE_W-1:0] p;
        i = a[PADDR_W-1:OFF_W];
        p = m_pe[i];
        if (!av) return 45'd0;
        return {p == NODE, p != NODE, p, a[OFF_W-1:0], m_mode[i], m_mode[i] == 2'b01};
    endfunction

    function automatic logic [44:0] actual_vec();
        if (!(out_local || out_remote)) return {out_local, out_remote, 43'd0};
        return {out_local, out_remote, out_pe, out_offset, out_mode, out_cached};
    endfunction

    task automatic check(input logic [44:0] exp, input string tag);
        logic [44:0] act;
        act = actual_vec();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare the result one edge later, update model.
    task automatic step(input logic we, input logic [IDX_W-1:0] wi, input logic [PE_W-1:0] wp,
                        input logic [1:0] wm, input logic av, input logic [PADDR_W-1:0] a,
                        input string tag);
        logic [44:0] exp;
        cfg_we = we; cfg_idx = wi; cfg_pe = wp; cfg_mode = wm;
        acc_valid = av; acc_addr = a;
        exp = expect_vec(av, a);
        @(posedge clk);
        #1;
        if (we) begin
            m_pe[wi] = wp;
            m_mode[wi] = wm;
        end
        check(exp, tag);
    endtask

    function automatic logic [PADDR_W-1:0] mk(input int idx, input logic [OFF_W-1:0] off);
        return {IDX_W'(idx), off};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1994));
        for (int i = 0; i < N; i++) begin
            m_pe[i] = NODE;
            m_mode[i] = 2'b00;
        end
        // R1: outputs low while held in reset, even with an access present
        acc_valid = 1'b1;
        acc_addr = mk(7, 29'h123);
        repeat (3) @(posedge clk);
        #1;
        check(45'd0, "R1 outputs in reset");
        rst_n = 1'b1;
        acc_valid = 1'b0;
        @(posedge clk);
        #1;
        // R1 R2: sweep all entries after reset: local, uncached, offset intact
        for (int i = 0; i < N; i++)
            step(1'b0, '0, '0, '0, 1'b1, mk(i, OFF_W'(i * 29'h0ABCDE1)), "R1 R2 reset entry");
        // R8: idle cycle gives no valid
        step(1'b0, '0, '0, '0, 1'b0, mk(3, 29'h1), "R8 idle");
        // R7: write entry 3 and access it in the same cycle -> old value
        step(1'b1, 5'd3, NODE + 11'd1, 2'b01, 1'b1, mk(3, 29'h1FFFFFFF), "R7 same-cycle old");
        // R7 R5 R6: next cycle sees remote cached
        step(1'b0, '0, '0, '0, 1'b1, mk(3, 29'h0), "R7 R5 R6 next-cycle new");
        // R10: neighbours untouched
        step(1'b0, '0, '0, '0, 1'b1, mk(2, 29'h55), "R10 neighbour 2");
        step(1'b0, '0, '0, '0, 1'b1, mk(4, 29'h66), "R10 neighbour 4");
        // R6: reserved codes read back but are not cached
        step(1'b1, 5'd31, 11'h7FF, 2'b10, 1'b0, '0, "R8 idle write");
        step(1'b0, '0, '0, '0, 1'b1, mk(31, 29'h1ABCDEF), "R6 code 10");
        step(1'b1, 5'd0, 11'h000, 2'b11, 1'b0, '0, "R8 idle write");
        step(1'b0, '0, '0, '0, 1'b1, mk(0, 29'h0), "R6 code 11");
        // R4: writing the node PE back steers local again
        step(1'b1, 5'd3, NODE, 2'b01, 1'b0, '0, "R8 idle write");
        step(1'b0, '0, '0, '0, 1'b1, mk(3, 29'h42), "R4 local cached");
        // R5: PE differing only in the top bit is remote
        step(1'b1, 5'd16, NODE ^ 11'h400, 2'b00, 1'b0, '0, "R8 idle write");
        step(1'b0, '0, '0, '0, 1'b1, mk(16, 29'h7), "R5 top-bit differs");
        // R3 R4 R5 R7 R10: random writes and accesses
        for (int k = 0; k < 600; k++) begin
            logic we;
            logic [PE_W-1:0] wp;
            we = ($urandom % 3) == 0;
            wp = (($urandom % 3) == 0) ? NODE : PE_W'($urandom);
            step(we, IDX_W'($urandom), wp, 2'($urandom), ($urandom % 4) != 0,
                 {IDX_W'($urandom), OFF_W'($urandom)}, "R3 R4 R5 R7 R10 random");
        end
        // R3: final sweep of every entry
        for (int i = 0; i < N; i++)
            step(1'b0, '0, '0, '0, 1'b1, mk(i, OFF_W'($urandom)), "R3 final sweep");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule